// File: doc/BRIEF.md
# Dual-Section Binary Ripple Counter

This block holds a four-bit binary count split into two independent sections. The low section is a single toggle stage that drives bit 0 of the output and divides its own count input by two. The high section is a three-bit binary counter that drives bits 3 down to 1, with bit 1 as its least significant bit, and divides its own count input by eight. Each section advances once for every high-to-low transition of its own count input. The two sections are not joined inside the block.

The whole block runs on one system clock. Both count inputs are passed through a synchronizer and then checked for falling edges, so they may be driven from any timing domain as long as every level lasts long enough to be sampled. A clear input pair, combined as an AND, empties both sections at once without waiting for a clock edge. The clear is released in step with the clock, and while it is in force no counting happens. For a full four-bit count, the user wires output bit 0 back to the high section's count input and drives count pulses into the low section's input. If only the high section's input is driven, the block works as a three-bit counter.

Top module: `dual_section_counter`

## Requirements
- R1: When clr_a_i and clr_b_i are both 1, q_o becomes 4'b0000 at once, without waiting for a clock edge.
- R2: If only one of clr_a_i and clr_b_i is 1, q_o does not change.
- R3: While both clear inputs are 1, falling edges on either count input leave q_o at 0.
- R4: A falling edge on cnt_a_i toggles q_o[0] exactly once. The change appears on the third rising clk edge after the first edge that samples the low level. Rising edges of cnt_a_i have no effect.
- R5: A falling edge on cnt_b_i adds one to the binary value q_o[3:1], where q_o[1] is the LSB. The latency is the same as in R4, and the value wraps from 7 to 0.
- R6: Edges on cnt_a_i never change q_o[3:1], and edges on cnt_b_i never change q_o[0].
- R7: With q_o[0] wired to cnt_b_i and pulses applied to cnt_a_i, q_o counts upward in binary as a 4-bit value and wraps from 15 to 0.
- R8: After the clear is released, the block recognises no count edge until the second rising clk edge. A count input that falls in the same cycle as the release is not counted.
- R9: A count input level that is held for at least two clk cycles is always detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and counting happen on its rising edge |
| cnt_a_i | input | 1 | Count input of the low (divide-by-two) section, falling-edge active |
| cnt_b_i | input | 1 | Count input of the high (divide-by-eight) section, falling-edge active |
| clr_a_i | input | 1 | Clear request, first half of the AND pair, active high |
| clr_b_i | input | 1 | Clear request, second half of the AND pair, active high |
| q_o | output | 4 | Count value: bit 0 from the low section, bits 3:1 from the high section |

## Verification
Each section's whole state is visible on q_o, so a wrong count or a lost edge shows up as a wrong output value three clock edges after the count input falls. The check comes after every single pulse, which ties a fault to the edge that caused it. The wrap points matter most: 1 to 0 in the low section, 7 to 0 in the high section, and 15 to 0 in cascade mode, because a carry or overflow fault shows only there. A fault in the clear path shows up as a nonzero output at once while both clear inputs are high, or as a count taken in the cycle the clear is released.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    // Width of the low section; the high section width is a top parameter.
    localparam int unsigned LO_W = 1;

    // Number of independent sections in the block.
    localparam int unsigned NUM_SEC = 2;

    // Registered state of one falling-edge detector.
    typedef struct packed {
        logic prev;
    } fall_extra_t;

    // Add one to a section count, wrapping naturally at its width.
    function automatic logic [7:0] step_count(input logic [7:0] cur, input int unsigned w);
        logic [7:0] mask;
        mask = 8'((9'd1 << w) - 9'd1);
        return (cur + 8'd1) & mask;
    endfunction

endpackage

// File: rtl/dsc_clear_sync.sv
module dsc_clear_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr_a_i,
    input  logic clr_b_i,
    output logic clr_async_o,
    output logic clear_active_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } clr_state_t;

    clr_state_t st_d, st_q;

    // Both halves must be high together to clear.
    assign clr_async_o = clr_a_i & clr_b_i;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], 1'b0};
    end

    // Set at once, released through the chain one clock at a time.
    always_ff @(posedge clk or posedge clr_async_o) begin
        if (clr_async_o) begin
            st_q.chain <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign clear_active_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/dsc_fall_detect.sv
module dsc_fall_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr_async_i,
    input  logic din_i,
    output logic fall_o
);

    import dsc_pkg::*;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        fall_extra_t       ext;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       level;

    assign level = st_q.sync[STAGES-1];

    always_comb begin
        st_d          = st_q;
        st_d.sync     = {st_q.sync[STAGES-2:0], din_i};
        st_d.ext.prev = level;
    end

    // Cleared to zero so a level present at release cannot look like an edge.
    always_ff @(posedge clk or posedge clr_async_i) begin
        if (clr_async_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.ext.prev & ~level;

endmodule

// File: rtl/dsc_section.sv
module dsc_section #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         clr_async_i,
    input  logic         hold_i,
    input  logic         step_i,
    output logic [W-1:0] q_o
);

    import dsc_pkg::*;

    typedef struct packed {
        logic [W-1:0] cnt;
    } sec_state_t;

    sec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i && !hold_i) begin
            st_d.cnt = W'(step_count(8'(st_q.cnt), W));
        end
    end

    always_ff @(posedge clk or posedge clr_async_i) begin
        if (clr_async_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.cnt;

endmodule

// File: rtl/dual_section_counter.sv
module dual_section_counter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HI_W        = 3
) (
    input  logic                           clk,
    input  logic                           cnt_a_i,
    input  logic                           cnt_b_i,
    input  logic                           clr_a_i,
    input  logic                           clr_b_i,
    output logic [dsc_pkg::LO_W+HI_W-1:0]  q_o
);

    import dsc_pkg::*;

    localparam int unsigned TOT_W = LO_W + HI_W;

    logic               clr_async;
    logic               clear_active;
    logic [NUM_SEC-1:0] cnt_in;
    logic [NUM_SEC-1:0] sec_fall;

    assign cnt_in = {cnt_b_i, cnt_a_i};

    dsc_clear_sync #(.STAGES(SYNC_STAGES)) u_clr (
        .clk            (clk),
        .clr_a_i        (clr_a_i),
        .clr_b_i        (clr_b_i),
        .clr_async_o    (clr_async),
        .clear_active_o (clear_active)
    );

    for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
        localparam int unsigned SW = (g == 0) ? LO_W : HI_W;
        logic [SW-1:0] sec_q;

        dsc_fall_detect #(.STAGES(SYNC_STAGES)) u_det (
            .clk         (clk),
            .clr_async_i (clr_async),
            .din_i       (cnt_in[g]),
            .fall_o      (sec_fall[g])
        );

        dsc_section #(.W(SW)) u_cnt (
            .clk         (clk),
            .clr_async_i (clr_async),
            .hold_i      (clear_active),
            .step_i      (sec_fall[g]),
            .q_o         (sec_q)
        );

        if (g == 0) begin : g_lo
            assign q_o[LO_W-1:0] = sec_q;
        end else begin : g_hi
            assign q_o[TOT_W-1:LO_W] = sec_q;
        end
    end

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int unsigned HI_W = 3
) (
    input logic            clk,
    input logic            clr_a,
    input logic            clr_b,
    input logic            clear_active,
    input logic [1:0]      fall,
    input logic [HI_W:0]   q
);

    // R1: both clear inputs high means an all-zero output
    a_r1_clear_zero: assert property (@(posedge clk)
        (clr_a && clr_b) |-> (q == '0));

    // R3: no counting while the synchronised clear is still held
    a_r3_hold_zero: assert property (@(posedge clk)
        (clear_active && clr_a && clr_b) |=> (q == '0));

    // R4: a detected low-section edge toggles bit 0
    a_r4_lo_toggle: assert property (@(posedge clk) disable iff (clear_active)
        fall[0] |=> (q[0] != $past(q[0])));

    // R5: a detected high-section edge adds one with wrap
    a_r5_hi_step: assert property (@(posedge clk) disable iff (clear_active)
        fall[1] |=> (q[HI_W:1] == HI_W'($past(q[HI_W:1]) + 1'b1)));

    // R6: no detected edge, no change in that section
    a_r6_lo_hold: assert property (@(posedge clk) disable iff (clear_active)
        !fall[0] |=> $stable(q[0]));

    a_r6_hi_hold: assert property (@(posedge clk) disable iff (clear_active)
        !fall[1] |=> $stable(q[HI_W:1]));

endmodule

bind dual_section_counter dsc_checker #(.HI_W(HI_W)) u_chk (
    .clk          (clk),
    .clr_a        (clr_a_i),
    .clr_b        (clr_b_i),
    .clear_active (clear_active),
    .fall         (sec_fall),
    .q            (q_o)
);

// File: tb/dual_section_counter_test.sv
module dual_section_counter_test;

    logic       clk = 1'b0;
    logic       cnt_a = 1'b0;
    logic       drv_b = 1'b0;
    logic       cascade = 1'b0;
    logic       clr_a = 1'b1;
    logic       clr_b = 1'b1;
    logic       cnt_b;
    logic [3:0] q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    int lo_m = 0;
    int hi_m = 0;

    always #4 clk = ~clk;

    assign cnt_b = cascade ? q[0] : drv_b;

    dual_section_counter uut (
        .clk     (clk),
        .cnt_a_i (cnt_a),
        .cnt_b_i (cnt_b),
        .clr_a_i (clr_a),
        .clr_b_i (clr_b),
        .q_o     (q)
    );

    function automatic logic [3:0] model();
        return 4'((hi_m << 1) | lo_m);
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: compares every queued expectation shortly after the negedge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(q, e.val, e.tag);
            end
        end
    end

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_a(input string tag);
        cnt_a = 1'b1;
        waitn(3);
        // A rising edge must have no effect (R4).
        exp_q.push_back('{model(), "R4 rise"});
        cnt_a = 1'b0;
        waitn(8);
        lo_m = lo_m ^ 1;
        if (cascade && lo_m == 0) hi_m = (hi_m + 1) % 8;
        exp_q.push_back('{model(), tag});
    endtask

    task automatic pulse_b(input string tag);
        drv_b = 1'b1;
        waitn(3);
        drv_b = 1'b0;
        waitn(4);
        hi_m = (hi_m + 1) % 8;
        exp_q.push_back('{model(), tag});
    endtask

    initial begin
        waitn(3);
        check(q, 4'b0000, "R1 reset state");
        @(negedge clk);
        clr_a = 1'b0;
        clr_b = 1'b0;
        waitn(4);

        // R4 timing: value still old after two edges, new after the third.
        cnt_a = 1'b1;
        waitn(4);
        cnt_a = 1'b0;
        waitn(2);
        #1 check(q, 4'b0000, "R4 latency early");
        waitn(1);
        #1 check(q, 4'b0001, "R4 latency on time");
        lo_m = 1;
        waitn(4);

        // Low section alone: wraps 1 -> 0, high untouched (R6).
        pulse_a("R4 wrap low section");
        pulse_a("R6 low pulse keeps high");

        // High section alone: 9 pulses wrap 7 -> 0 (R5, R6).
        for (int i = 0; i < 9; i++) pulse_b("R5 high section count");
        pulse_a("R6 toggle low with high at 1");
        pulse_b("R6 high pulse keeps low");

        // R9: minimum-width levels of exactly two cycles.
        drv_b = 1'b1; waitn(2); drv_b = 1'b0; waitn(2);
        drv_b = 1'b1; waitn(2); drv_b = 1'b0; waitn(5);
        hi_m = (hi_m + 2) % 8;
        exp_q.push_back('{model(), "R9 two-cycle levels"});
        waitn(1);

        // R2: one clear half alone has no effect.
        clr_a = 1'b1; waitn(3);
        exp_q.push_back('{model(), "R2 clr_a alone"});
        waitn(1);
        clr_a = 1'b0; clr_b = 1'b1; waitn(3);
        exp_q.push_back('{model(), "R2 clr_b alone"});
        waitn(1);
        clr_b = 1'b0; waitn(2);

        // R1: asynchronous clear, seen before the next clock edge.
        @(posedge clk);
        #1;
        clr_a = 1'b1; clr_b = 1'b1;
        #1 check(q, 4'b0000, "R1 asynchronous clear");
        lo_m = 0; hi_m = 0;

        // R3: pulses during clear are ignored.
        @(negedge clk);
        cnt_a = 1'b1; drv_b = 1'b1; waitn(3);
        cnt_a = 1'b0; drv_b = 1'b0; waitn(6);
        exp_q.push_back('{4'b0000, "R3 pulses under clear"});
        waitn(1);

        // R8: count input falls together with release; no count.
        cnt_a = 1'b1; drv_b = 1'b1; waitn(3);
        cnt_a = 1'b0; drv_b = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
        waitn(8);
        exp_q.push_back('{4'b0000, "R8 edge at release ignored"});
        waitn(1);

        // R7: cascade mode, 17 pulses through the 15 -> 0 wrap.
        cascade = 1'b1;
        for (int i = 0; i < 17; i++) pulse_a("R7 cascade count");
        waitn(2);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule